// File: doc/BRIEF.md
# Frame BIP-8 Parity Error Monitor

This block watches a byte stream that a frame aligner has already delineated into E3 frames. Each accepted byte comes with a start-of-frame strobe, and markers that flag the error-monitoring (EM) overhead byte and the maintenance (MA) overhead byte. The block folds every byte of a frame, overhead included, into an 8-bit interleaved parity. That parity is held until the EM byte of the next frame arrives. The block then reports the XOR of the two as an error pattern, raises a per-frame error flag and pulses a request that asks the local transmit formatter to send a remote error indication.

Two saturating event counters run beside the checker. One counts local parity errors, either per differing bit or per errored frame as `bit_mode` selects. The other counts remote error indications found in the MA byte. A `latch` strobe moves both live counts into holding registers and restarts the live counters. An increment that arrives on the latch cycle is kept and counts toward the new period.

The input is a valid/ready stream. `in_ready` is tied high, so the block never applies back-pressure and a byte is consumed on every cycle in which `in_valid` is high. While `in_valid` is low, the data and marker inputs are ignored.

Top module: `bip_err_monitor`

## Requirements
- R1: The parity of a frame is the XOR of every accepted byte from its start-of-frame byte up to, but not including, the next start-of-frame byte. The EM and MA bytes are part of this XOR.
- R2: When the EM byte of frame N+1 is accepted, `err_valid` is high for exactly one cycle, starting on the cycle after that byte. In that cycle `err_pattern` equals the EM byte XOR the parity of frame N.
- R3: With `bit_mode`=1, the local error count rises by the number of 1 bits in the error pattern, from 0 to 8 per frame.
- R4: With `bit_mode`=0, the local error count rises by 1 for a non-zero error pattern and by 0 otherwise.
- R5: `parity_err` holds the outcome of the most recent comparison (1 means a non-zero pattern). `rei_req` pulses for one cycle, together with `err_valid`, for each frame whose pattern is non-zero.
- R6: No comparison is made for the first EM byte after reset or after an `align_lost` pulse, because no complete earlier frame exists yet. The comparison resumes with the frame after that one.
- R7: The remote error bit is bit 2 of the MA byte, numbering bits 1 to 8 from MSB to LSB (`in_data[6]`). A 1 in that bit adds one to the remote error count.
- R8: Both counts are 16 bits wide and stop at 65535 instead of wrapping.
- R9: On a cycle with `latch` high, each holding register takes the live count and the live counter restarts at that cycle's increment, so no event is lost.
- R10: `in_ready` is always 1. Bytes and markers presented with `in_valid` low have no effect on parity, comparisons or counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Always 1, no back-pressure |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_em | input | 1 | Byte is the EM parity byte |
| in_ma | input | 1 | Byte is the MA maintenance byte |
| align_lost | input | 1 | Frame alignment lost, discard parity history |
| bit_mode | input | 1 | 1 = count per bit, 0 = count per frame |
| latch | input | 1 | Move counts to holding registers and restart |
| err_valid | output | 1 | One-cycle comparison result strobe |
| err_pattern | output | 8 | EM byte XOR previous frame parity |
| parity_err | output | 1 | Outcome of the latest comparison |
| rei_req | output | 1 | Remote error indication request pulse |
| bip_hold | output | 16 | Latched local parity error count |
| rei_hold | output | 16 | Latched remote error count |

## Verification
The in-line assertions check, on every cycle, the following properties: that the counters never wrap and stay pinned at full scale, that a latch copies the live count, that the per-frame increment stays within its mode's limit, that `rei_req` only appears with a non-zero comparison, and that `align_lost` clears the parity history. Other behaviours can only be shown by the bench's scenarios against its own parity model. These are whether the parity really covers every byte, whether it is matched against the following frame's EM byte, whether the remote error bit is taken from the right position, and whether an increment on the latch cycle lands in the new period.

// File: rtl/bip_mon_pkg.sv
package bip_mon_pkg;

  function automatic int unsigned ones_count(input logic [31:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < n; i++) c += v[i];
    return c;
  endfunction

endpackage

// File: rtl/bip_accum.sv
module bip_accum #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [DATA_W-1:0] data,
  input  logic              sof,
  input  logic              align_lost,
  output logic [DATA_W-1:0] cmp_par,
  output logic              cmp_ok
);
  logic [DATA_W-1:0] acc_q, prev_q;
  logic              prev_ok_q, seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
      seen_q    <= 1'b0;
    end else if (align_lost) begin
      prev_ok_q <= 1'b0;
      seen_q    <= 1'b0;
    end else if (beat) begin
      if (sof) begin
        acc_q     <= data;
        prev_q    <= acc_q;
        prev_ok_q <= seen_q;
        seen_q    <= 1'b1;
      end else begin
        acc_q <= acc_q ^ data;
      end
    end
  end

  // An EM byte sitting on a frame start compares against the frame just closed.
  assign cmp_par = sof ? acc_q : prev_q;
  assign cmp_ok  = !align_lost && (sof ? seen_q : prev_ok_q);

  assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    align_lost |=> (!prev_ok_q && !seen_q));

  assert_history_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prev_ok_q |-> seen_q);

endmodule

// File: rtl/em_compare.sv
module em_compare #(
  parameter int DATA_W = 8,
  parameter int INC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              em,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] cmp_par,
  input  logic              cmp_ok,
  input  logic              bit_mode,
  output logic              err_valid,
  output logic [DATA_W-1:0] err_pattern,
  output logic              parity_err,
  output logic              rei_req,
  output logic [INC_W-1:0]  bip_inc
);
  import bip_mon_pkg::*;

  logic              ev_q, perr_q, req_q;
  logic [DATA_W-1:0] pat_q;
  logic              take;
  logic              mismatch;

  assign take     = beat && em && cmp_ok;
  assign mismatch = (data != cmp_par);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q   <= 1'b0;
      req_q  <= 1'b0;
      perr_q <= 1'b0;
      pat_q  <= '0;
    end else begin
      ev_q  <= take;
      req_q <= take && mismatch;
      if (take) begin
        pat_q  <= data ^ cmp_par;
        perr_q <= mismatch;
      end
    end
  end

  always_comb begin
    bip_inc = '0;
    if (ev_q) begin
      if (bit_mode) bip_inc = INC_W'(ones_count(32'(pat_q), DATA_W));
      else          bip_inc = INC_W'(perr_q);
    end
  end

  assign err_valid   = ev_q;
  assign err_pattern = pat_q;
  assign parity_err  = perr_q;
  assign rei_req     = req_q;

  assert_rei_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rei_req |-> (err_valid && parity_err && err_pattern != '0));

  assert_bit_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bip_inc <= INC_W'(DATA_W));

  assert_block_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_mode |-> bip_inc <= 1);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |-> bip_inc == '0);

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CNT_W = 16,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  input  logic             latch,
  output logic [CNT_W-1:0] hold
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hold  <= '0;
    end else if (latch) begin
      hold  <= cnt_q;
      cnt_q <= CNT_W'(inc);
    end else begin
      cnt_q <= sum[CNT_W] ? MAXV : sum[CNT_W-1:0];
    end
  end

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> cnt_q >= $past(cnt_q));

  assert_pinned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch && cnt_q == MAXV) |=> cnt_q == MAXV);

  assert_latch_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> (hold == $past(cnt_q) && cnt_q == CNT_W'($past(inc))));

endmodule

// File: rtl/bip_err_monitor.sv
module bip_err_monitor #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int REI_BIT_NUM = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_em,
  input  logic              in_ma,
  input  logic              align_lost,
  input  logic              bit_mode,
  input  logic              latch,
  output logic              err_valid,
  output logic [DATA_W-1:0] err_pattern,
  output logic              parity_err,
  output logic              rei_req,
  output logic [CNT_W-1:0]  bip_hold,
  output logic [CNT_W-1:0]  rei_hold
);
  localparam int INC_W   = $clog2(DATA_W + 1);
  localparam int REI_IDX = DATA_W - REI_BIT_NUM;
  localparam int N_CNT   = 2;

  logic              beat;
  logic [DATA_W-1:0] cmp_par;
  logic              cmp_ok;
  logic [INC_W-1:0]  bip_inc;
  logic              far_q;
  logic [INC_W-1:0]  inc_arr  [N_CNT];
  logic [CNT_W-1:0]  hold_arr [N_CNT];

  assign in_ready = 1'b1;
  assign beat     = in_valid;

  bip_accum #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .beat(beat), .data(in_data), .sof(in_sof),
    .align_lost(align_lost), .cmp_par(cmp_par), .cmp_ok(cmp_ok)
  );

  em_compare #(.DATA_W(DATA_W), .INC_W(INC_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .beat(beat), .em(in_em), .data(in_data),
    .cmp_par(cmp_par), .cmp_ok(cmp_ok), .bit_mode(bit_mode),
    .err_valid(err_valid), .err_pattern(err_pattern), .parity_err(parity_err),
    .rei_req(rei_req), .bip_inc(bip_inc)
  );

  // Remote error bit of the MA byte, registered to line up with the local path.
  always_ff @(posedge clk) begin
    if (!rst_n) far_q <= 1'b0;
    else        far_q <= beat && in_ma && in_data[REI_IDX];
  end

  assign inc_arr[0] = bip_inc;
  assign inc_arr[1] = INC_W'(far_q);

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc_arr[g]), .latch(latch), .hold(hold_arr[g])
    );
  end

  assign bip_hold = hold_arr[0];
  assign rei_hold = hold_arr[1];

  assert_far_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    far_q |-> $past(in_valid && in_ma));

endmodule

// File: tb/bip_err_monitor_test.sv
module bip_err_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_em = 0, in_ma = 0;
  logic align_lost = 0, bit_mode = 1, latch = 0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, err_valid, parity_err, rei_req;
  logic [7:0] err_pattern;
  logic [15:0] bip_hold, rei_hold;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] acc_m = 0, prev_m = 0;
  bit prev_ok_m = 0, seen_m = 0;
  int bip_m = 0, rei_m = 0, fcount = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bip_err_monitor uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_em(in_em), .in_ma(in_ma),
    .align_lost(align_lost), .bit_mode(bit_mode), .latch(latch),
    .err_valid(err_valid), .err_pattern(err_pattern), .parity_err(parity_err),
    .rei_req(rei_req), .bip_hold(bip_hold), .rei_hold(rei_hold)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pop8(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += v[i];
    return c;
  endfunction

  // Monitor: pops expected comparison results as the design emits them.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (err_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6", "unexpected err_valid", 1, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(err_pattern == e, "R2", "err_pattern", err_pattern, e);
          chk(parity_err == (e != 0), "R5", "parity_err", parity_err, e != 0);
          chk(rei_req == (e != 0), "R5", "rei_req", rei_req, e != 0);
        end
      end else begin
        if (rei_req) chk(0, "R5", "rei_req without err_valid", 1, 0);
      end
    end
  end

  task automatic drive(input logic [7:0] d, input bit s, input bit e, input bit m, input bit l);
    @(negedge clk);
    in_valid = 1; in_data = d; in_sof = s; in_em = e; in_ma = m; latch = l;
  endtask

  // R10: idle cycles present garbage with markers raised but valid low.
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_data = 8'hA5 ^ 8'(i); in_sof = 1; in_em = 1; in_ma = 1; latch = 0;
    end
    @(negedge clk);
    in_sof = 0; in_em = 0; in_ma = 0;
  endtask

  task automatic send_frame(input logic [7:0] emask, input bit rei_bit, input bit lat);
    logic [7:0] em, ma, p;
    int inc;
    int old_b, old_r;
    // start of frame (R1)
    prev_m = acc_m; prev_ok_m = seen_m; seen_m = 1; acc_m = 8'hF6;
    drive(8'hF6, 1, 0, 0, 0);
    drive(8'h28, 0, 0, 0, 0); acc_m ^= 8'h28;
    em = prev_ok_m ? (prev_m ^ emask) : (8'h3C ^ emask);
    inc = 0;
    if (prev_ok_m) begin
      exp_q.push_back(emask);
      inc = bit_mode ? pop8(emask) : int'(emask != 0);
    end
    drive(em, 0, 1, 0, 0); acc_m ^= em;
    // R7: bit 2 (MSB-first) is the remote error bit; bit 1 set as a decoy.
    ma = {1'b1, rei_bit, 6'b001010};
    drive(ma, 0, 0, 1, lat); acc_m ^= ma;
    old_b = bip_m; old_r = rei_m;
    if (lat) begin
      bip_m = inc; rei_m = int'(rei_bit);
    end else begin
      bip_m = (bip_m + inc > 65535) ? 65535 : bip_m + inc;
      rei_m = (rei_m + int'(rei_bit) > 65535) ? 65535 : rei_m + int'(rei_bit);
    end
    p = 8'(fcount * 37 + 5);
    drive(p, 0, 0, 0, 0); acc_m ^= p;
    if (lat) begin
      chk(bip_hold == 16'(old_b), "R9", "bip_hold on MA-cycle latch", bip_hold, old_b);
      chk(rei_hold == 16'(old_r), "R9", "rei_hold on MA-cycle latch", rei_hold, old_r);
    end
    p = 8'(fcount * 91 + 3);
    drive(p, 0, 0, 0, 0); acc_m ^= p;
    fcount++;
  endtask

  task automatic latch_check(input string req);
    idle(3);
    @(negedge clk); in_valid = 0; latch = 1;
    @(negedge clk); latch = 0;
    chk(bip_hold == 16'(bip_m), req, "bip_hold", bip_hold, bip_m);
    chk(rei_hold == 16'(rei_m), req, "rei_hold", rei_hold, rei_m);
    chk(exp_q.size() == 0, "R2", "pending comparisons", exp_q.size(), 0);
    bip_m = 0; rei_m = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(err_valid == 0, "R2", "reset err_valid", err_valid, 0);
    chk(bip_hold == 0 && rei_hold == 0, "R9", "reset holds", bip_hold, 0);
    chk(in_ready == 1, "R10", "in_ready", in_ready, 1);
    rst_n = 1;
    // bit mode, first frame not compared (R6), then varied patterns (R3, R7)
    bit_mode = 1;
    send_frame(8'h00, 1, 0);
    send_frame(8'h00, 0, 0);
    idle(2);
    send_frame(8'h81, 1, 0);
    send_frame(8'hFF, 0, 0);
    idle(1);
    send_frame(8'h10, 1, 0);
    latch_check("R3");
    // block mode (R4)
    idle(1); bit_mode = 0;
    send_frame(8'h0F, 0, 0);
    send_frame(8'h00, 1, 0);
    send_frame(8'h80, 0, 0);
    latch_check("R4");
    // alignment loss (R6)
    bit_mode = 1;
    @(negedge clk); align_lost = 1;
    @(negedge clk); align_lost = 0;
    seen_m = 0; prev_ok_m = 0;
    send_frame(8'hFF, 0, 0);
    send_frame(8'h02, 1, 0);
    latch_check("R6");
    // latch on the same cycle as an increment (R9)
    send_frame(8'h07, 1, 0);
    send_frame(8'h33, 1, 1);
    latch_check("R9");
    // saturation (R8)
    for (int k = 0; k < 8200; k++) send_frame(8'hFF, 0, 0);
    latch_check("R8");
    chk(bip_m == 0, "R8", "model cleared", bip_m, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule